// File: doc/BRIEF.md
# Detector Frame Readout Sequencer

This block is the controller for reading one frame out of an infrared detector array. A single-cycle start request launches a frame, and a read-flag input chooses the mode. With the flag low the sequencer makes one array read. With the flag high it makes two reads with an integration interval between them, for correlated double sampling. The integration length comes from a programmable cycle count. The flag and the integration count are both captured when the start request is accepted.

The sequencer has two levels. The upper level steps through a reset phase, a row scan, a per-row column scan and an integration phase. Inside the reset phase, three timed sub-steps run in a fixed order: clamp-and-setup, row-array reset and global reset. The second read of a double-sampled frame is preceded only by the clamp-and-setup step. The outputs are:
- a one-hot phase indicator;
- a reset sub-step code;
- the row index, and a two-bit row variant taken from the row index modulo 4;
- the column index;
- odd and even pixel strobes;
- the number of the current read;
- a one-cycle array-end pulse and a one-cycle done pulse.

All durations, array dimensions and counter widths are parameters. The default values describe a 2048-row array with 16 columns per row.

State machine: IDLE, CLAMP, ROWRST, GLBRST, ROWARM, PIXODD, PIXEVEN, LASTPIX, ARREND, INTEG. The transitions are:
- IDLE→CLAMP on start.
- CLAMP→ROWRST at the end of the clamp step of read 1.
- CLAMP→ROWARM at the end of the clamp step of read 2.
- ROWRST→GLBRST when the row-array reset times out.
- GLBRST→ROWARM when the global reset times out.
- ROWARM→PIXODD.
- PIXODD→PIXEVEN.
- PIXEVEN→PIXODD while columns remain.
- PIXEVEN→LASTPIX when the column count reaches the column total.
- LASTPIX→ROWARM when more rows remain.
- LASTPIX→ARREND after the last row.
- ARREND→INTEG after read 1 of a double-sampled frame.
- ARREND→IDLE otherwise.
- INTEG→CLAMP when the integration time expires.

Top module: `ir_frame_sequencer`

## Requirements
- R1: After a synchronous reset, and whenever idle, every output is zero. This includes phase_o, reset_step_o, the row and column indices, read_idx_o and both pulses.
- R2: Read 1 begins with the reset phase (phase_o = 4'b0001). Its sub-steps run in this order: clamp (reset_step_o = 2'b01) for CLAMP_CYC cycles, row-array reset (2'b10) for ROWRST_CYC cycles, then global reset (2'b11) for GLBRST_CYC cycles. The first clamp cycle is the cycle after start is sampled.
- R3: The row scan runs row_idx_o from 0 to ROWS-1 in steps of one. Each row is an arm cycle, then its pixel reads, then a last-pixel cycle. After the last pixel of row ROWS-1 comes one array-end cycle (array_end_o = 1, row_idx_o = ROWS-1).
- R4: row_type_o equals row_idx_o modulo 4, giving the codes 00, 01, 10 and 11.
- R5: In the arm cycle col_idx_o is 0. Then, for each column c from 0 to COLS-1, there is one cycle with pix_odd_o = 1 followed by one cycle with pix_even_o = 1, both showing col_idx_o = c. The column phase is phase_o = 4'b0100. The last-pixel cycle shows col_idx_o = COLS.
- R6: With the read flag low at start, only one read is made. done_o is high in that read's array-end cycle, and read_idx_o is 1 throughout the frame.
- R7: With the read flag high at start, the array-end cycle of read 1 is followed by integration (phase_o = 4'b1000, read_idx_o = 1) for the captured count. Then comes a clamp step (2'b01, CLAMP_CYC cycles) with no row-array or global reset, then a second read with read_idx_o = 2. done_o is high in the array-end cycle of read 2.
- R8: An integration count of 0 gives one integration cycle. The read flag and the integration count are sampled only with the accepted start.
- R9: A start request while the sequencer is not idle has no effect on the running frame.
- R10: done_o is high for exactly one cycle, and the next cycle is idle.
- R11: A synchronous reset in the middle of a frame returns the block to idle with all counters zero. A later start then runs a complete frame.
- R12: phase_o has at most one bit set. Bit 0 is the reset phase, bit 1 the row phase (arm, last pixel, array end), bit 2 the column phase and bit 3 integration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Frame start request |
| read_flag_i | input | 1 | 1 = double read with integration, 0 = single read |
| int_cycles_i | input | INT_W | Integration length in cycles |
| phase_o | output | 4 | One-hot phase: reset, row, column, integrate |
| reset_step_o | output | 2 | Reset sub-step: 01 clamp, 10 row-array, 11 global |
| row_idx_o | output | ROW_W | Current row index |
| row_type_o | output | 2 | Row variant, row index modulo 4 |
| col_idx_o | output | COL_W | Current column index |
| pix_odd_o | output | 1 | Odd-pixel read strobe |
| pix_even_o | output | 1 | Even-pixel read strobe |
| read_idx_o | output | 2 | Current read number (1 or 2) |
| array_end_o | output | 1 | One-cycle array-end pulse |
| done_o | output | 1 | One-cycle frame-done pulse |

## Verification
The bench builds the sequencer with ROWS=6 and COLS=3, reset sub-steps of 2, 3 and 5 cycles, and an 8-bit integration count. A whole single or double frame therefore takes well under two hundred cycles. Six rows make the row variant wrap through all four codes and back to 00 and 01. Three columns exercise both the continue branch and the last-pixel branch of the column loop. The short durations let every cycle of every frame be compared with an independent trace. That trace covers both read modes, the zero-length integration and a reset in the middle of a frame.

// File: rtl/frame_seq_pkg.sv
`timescale 1ns/1ps
package frame_seq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CLAMP,
        ST_ROWRST,
        ST_GLBRST,
        ST_ROWARM,
        ST_PIXODD,
        ST_PIXEVEN,
        ST_LASTPIX,
        ST_ARREND,
        ST_INTEG
    } seq_state_t;

    // Bit positions inside the one-hot phase vector
    localparam int PH_RESET = 0;
    localparam int PH_ROW   = 1;
    localparam int PH_COL   = 2;
    localparam int PH_INTEG = 3;

    typedef enum logic [1:0] {
        STEP_NONE   = 2'b00,
        STEP_CLAMP  = 2'b01,
        STEP_ROWRST = 2'b10,
        STEP_GLBRST = 2'b11
    } rst_step_t;

endpackage

// File: rtl/frame_seq_timer.sv
`timescale 1ns/1ps
// Down-counting duration timer: loaded on entry to a timed state,
// last_o marks the final cycle of that state. A length of 0 acts as 1.
module frame_seq_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_i,
    input  logic [W-1:0] len_i,
    output logic         last_o
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= (len_i == '0) ? W'(1) : len_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - W'(1);
        end
    end

    assign last_o = (cnt_q <= W'(1));

endmodule

// File: rtl/frame_seq_idx_ctr.sv
`timescale 1ns/1ps
// Index counter with synchronous clear (priority) and increment.
module frame_seq_idx_ctr #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr_i,
    input  logic         inc_i,
    output logic [W-1:0] val_o
);

    logic [W-1:0] val_q;

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            val_q <= '0;
        end else if (inc_i) begin
            val_q <= val_q + W'(1);
        end
    end

    assign val_o = val_q;

endmodule

// File: rtl/ir_frame_sequencer.sv
`timescale 1ns/1ps
module ir_frame_sequencer
    import frame_seq_pkg::*;
#(
    parameter int ROWS       = 2048,
    parameter int COLS       = 16,
    parameter int CLAMP_CYC  = 4,
    parameter int ROWRST_CYC = 10,
    parameter int GLBRST_CYC = 582,
    parameter int INT_W      = 16,
    localparam int ROW_W     = (ROWS > 1) ? $clog2(ROWS) : 1,
    localparam int COL_W     = $clog2(COLS + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             read_flag_i,
    input  logic [INT_W-1:0] int_cycles_i,
    output logic [3:0]       phase_o,
    output logic [1:0]       reset_step_o,
    output logic [ROW_W-1:0] row_idx_o,
    output logic [1:0]       row_type_o,
    output logic [COL_W-1:0] col_idx_o,
    output logic             pix_odd_o,
    output logic             pix_even_o,
    output logic [1:0]       read_idx_o,
    output logic             array_end_o,
    output logic             done_o
);

    localparam logic [INT_W-1:0] LEN_CLAMP  = INT_W'(CLAMP_CYC);
    localparam logic [INT_W-1:0] LEN_ROWRST = INT_W'(ROWRST_CYC);
    localparam logic [INT_W-1:0] LEN_GLBRST = INT_W'(GLBRST_CYC);
    localparam logic [ROW_W-1:0] ROW_LAST   = ROW_W'(ROWS - 1);
    localparam logic [COL_W-1:0] COL_LAST   = COL_W'(COLS - 1);

    seq_state_t       state_q, state_d;
    logic             dbl_q;
    logic [INT_W-1:0] int_len_q;
    logic [1:0]       read_q;

    logic             tmr_load, tmr_last;
    logic [INT_W-1:0] tmr_len;
    logic             row_clr, row_inc, col_clr, col_inc;
    logic [ROW_W-1:0] row_q;
    logic [COL_W-1:0] col_q;
    logic             second_pending;

    // A second read is still owed after read 1 of a double-sampled frame
    assign second_pending = dbl_q && (read_q == 2'd1);

    frame_seq_timer #(.W(INT_W)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .load_i (tmr_load),
        .len_i  (tmr_len),
        .last_o (tmr_last)
    );

    frame_seq_idx_ctr #(.W(ROW_W)) u_row_ctr (
        .clk    (clk),
        .rst    (rst),
        .clr_i  (row_clr),
        .inc_i  (row_inc),
        .val_o  (row_q)
    );

    frame_seq_idx_ctr #(.W(COL_W)) u_col_ctr (
        .clk    (clk),
        .rst    (rst),
        .clr_i  (col_clr),
        .inc_i  (col_inc),
        .val_o  (col_q)
    );

    // Next-state and control decode
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_len  = '0;
        row_clr  = 1'b0;
        row_inc  = 1'b0;
        col_clr  = 1'b0;
        col_inc  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    state_d  = ST_CLAMP;
                    tmr_load = 1'b1;
                    tmr_len  = LEN_CLAMP;
                end
            end
            ST_CLAMP: begin
                if (tmr_last) begin
                    if (read_q == 2'd1) begin
                        state_d  = ST_ROWRST;
                        tmr_load = 1'b1;
                        tmr_len  = LEN_ROWRST;
                    end else begin
                        state_d  = ST_ROWARM;
                    end
                end
            end
            ST_ROWRST: begin
                if (tmr_last) begin
                    state_d  = ST_GLBRST;
                    tmr_load = 1'b1;
                    tmr_len  = LEN_GLBRST;
                end
            end
            ST_GLBRST: begin
                if (tmr_last) state_d = ST_ROWARM;
            end
            ST_ROWARM: begin
                state_d = ST_PIXODD;
            end
            ST_PIXODD: begin
                state_d = ST_PIXEVEN;
            end
            ST_PIXEVEN: begin
                col_inc = 1'b1;
                state_d = (col_q == COL_LAST) ? ST_LASTPIX : ST_PIXODD;
            end
            ST_LASTPIX: begin
                col_clr = 1'b1;
                if (row_q == ROW_LAST) begin
                    state_d = ST_ARREND;
                end else begin
                    row_inc = 1'b1;
                    state_d = ST_ROWARM;
                end
            end
            ST_ARREND: begin
                row_clr = 1'b1;
                if (second_pending) begin
                    state_d  = ST_INTEG;
                    tmr_load = 1'b1;
                    tmr_len  = int_len_q;
                end else begin
                    state_d  = ST_IDLE;
                end
            end
            ST_INTEG: begin
                if (tmr_last) begin
                    state_d  = ST_CLAMP;
                    tmr_load = 1'b1;
                    tmr_len  = LEN_CLAMP;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State and frame-context registers
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            dbl_q     <= 1'b0;
            int_len_q <= '0;
            read_q    <= 2'd0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && start_i) begin
                dbl_q     <= read_flag_i;
                int_len_q <= int_cycles_i;
                read_q    <= 2'd1;
            end else if (state_q == ST_INTEG && tmr_last) begin
                read_q    <= 2'd2;
            end else if (state_q == ST_ARREND && !second_pending) begin
                read_q    <= 2'd0;
            end
        end
    end

    // Moore outputs
    always_comb begin
        phase_o      = 4'b0000;
        reset_step_o = STEP_NONE;
        pix_odd_o    = 1'b0;
        pix_even_o   = 1'b0;
        array_end_o  = 1'b0;
        done_o       = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_CLAMP: begin
                phase_o[PH_RESET] = 1'b1;
                reset_step_o      = STEP_CLAMP;
            end
            ST_ROWRST: begin
                phase_o[PH_RESET] = 1'b1;
                reset_step_o      = STEP_ROWRST;
            end
            ST_GLBRST: begin
                phase_o[PH_RESET] = 1'b1;
                reset_step_o      = STEP_GLBRST;
            end
            ST_ROWARM, ST_LASTPIX: begin
                phase_o[PH_ROW] = 1'b1;
            end
            ST_PIXODD: begin
                phase_o[PH_COL] = 1'b1;
                pix_odd_o       = 1'b1;
            end
            ST_PIXEVEN: begin
                phase_o[PH_COL] = 1'b1;
                pix_even_o      = 1'b1;
            end
            ST_ARREND: begin
                phase_o[PH_ROW] = 1'b1;
                array_end_o     = 1'b1;
                done_o          = !second_pending;
            end
            ST_INTEG: begin
                phase_o[PH_INTEG] = 1'b1;
            end
            default: ;
        endcase
    end

    assign row_idx_o  = row_q;
    assign col_idx_o  = col_q;
    assign read_idx_o = read_q;

    generate
        if (ROW_W >= 2) begin : g_rtype_wide
            assign row_type_o = row_q[1:0];
        end else begin : g_rtype_narrow
            assign row_type_o = {1'b0, row_q};
        end
    endgenerate

endmodule

// File: rtl/frame_seq_checks.sv
`timescale 1ns/1ps
module frame_seq_checks #(
    parameter int ROW_W = 11,
    parameter int COL_W = 5,
    parameter int COLS  = 16
) (
    input logic             clk,
    input logic             rst,
    input logic [3:0]       phase_o,
    input logic [1:0]       reset_step_o,
    input logic [ROW_W-1:0] row_idx_o,
    input logic [COL_W-1:0] col_idx_o,
    input logic             pix_odd_o,
    input logic             pix_even_o,
    input logic             array_end_o,
    input logic             done_o
);

    assert_phase_onehot_R12: assert property (@(posedge clk) disable iff (rst)
        $onehot0(phase_o));

    assert_even_after_odd_R5: assert property (@(posedge clk) disable iff (rst)
        pix_odd_o |=> pix_even_o);

    assert_col_bound_R5: assert property (@(posedge clk) disable iff (rst)
        col_idx_o <= COL_W'(COLS));

    assert_row_step_R3: assert property (@(posedge clk) disable iff (rst)
        !$stable(row_idx_o) |->
            (row_idx_o == ROW_W'($past(row_idx_o) + 1'b1) || row_idx_o == '0));

    assert_done_at_end_R6: assert property (@(posedge clk) disable iff (rst)
        done_o |-> array_end_o);

    assert_done_single_R10: assert property (@(posedge clk) disable iff (rst)
        done_o |=> (!done_o && phase_o == 4'b0000));

    assert_integ_then_clamp_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(phase_o[3]) |-> (reset_step_o == 2'b01));

endmodule

bind ir_frame_sequencer frame_seq_checks #(
    .ROW_W (ROW_W),
    .COL_W (COL_W),
    .COLS  (COLS)
) u_checks (
    .clk          (clk),
    .rst          (rst),
    .phase_o      (phase_o),
    .reset_step_o (reset_step_o),
    .row_idx_o    (row_idx_o),
    .col_idx_o    (col_idx_o),
    .pix_odd_o    (pix_odd_o),
    .pix_even_o   (pix_even_o),
    .array_end_o  (array_end_o),
    .done_o       (done_o)
);

// File: tb/test_ir_frame_sequencer.sv
`timescale 1ns/1ps
module test_ir_frame_sequencer;

    localparam int ROWS  = 6;
    localparam int COLS  = 3;
    localparam int CL    = 2;
    localparam int RR    = 3;
    localparam int GR    = 5;
    localparam int INT_W = 8;
    localparam int ROW_W = $clog2(ROWS);
    localparam int COL_W = $clog2(COLS + 1);

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start_i = 1'b0;
    logic             read_flag_i = 1'b0;
    logic [INT_W-1:0] int_cycles_i = '0;
    logic [3:0]       phase_o;
    logic [1:0]       reset_step_o;
    logic [ROW_W-1:0] row_idx_o;
    logic [1:0]       row_type_o;
    logic [COL_W-1:0] col_idx_o;
    logic             pix_odd_o, pix_even_o;
    logic [1:0]       read_idx_o;
    logic             array_end_o, done_o;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    ir_frame_sequencer #(
        .ROWS(ROWS), .COLS(COLS), .CLAMP_CYC(CL), .ROWRST_CYC(RR),
        .GLBRST_CYC(GR), .INT_W(INT_W)
    ) i_ir_frame_sequencer (
        .clk(clk), .rst(rst), .start_i(start_i), .read_flag_i(read_flag_i),
        .int_cycles_i(int_cycles_i), .phase_o(phase_o),
        .reset_step_o(reset_step_o), .row_idx_o(row_idx_o),
        .row_type_o(row_type_o), .col_idx_o(col_idx_o),
        .pix_odd_o(pix_odd_o), .pix_even_o(pix_even_o),
        .read_idx_o(read_idx_o), .array_end_o(array_end_o), .done_o(done_o)
    );

    // Wait for the falling edge, then compare every output with the expectation
    task automatic chk_cyc(string tag, logic [3:0] ph, logic [1:0] st, int row,
                           int col, bit odd, bit even, bit aend, bit dn, int rd);
        logic [3:0] exp_rt;
        @(negedge clk);
        exp_rt = 4'(row % 4);
        checks++;
        if (phase_o !== ph || reset_step_o !== st || row_idx_o !== ROW_W'(row) ||
            row_type_o !== exp_rt[1:0] || col_idx_o !== COL_W'(col) ||
            pix_odd_o !== odd || pix_even_o !== even || array_end_o !== aend ||
            done_o !== dn || read_idx_o !== 2'(rd)) begin
            fails++;
            $display("FAIL %s t=%0t: got ph=%b st=%b row=%0d rt=%0d col=%0d o=%b e=%b ae=%b dn=%b rd=%0d exp ph=%b st=%b row=%0d rt=%0d col=%0d o=%b e=%b ae=%b dn=%b rd=%0d",
                     tag, $time, phase_o, reset_step_o, row_idx_o, row_type_o, col_idx_o,
                     pix_odd_o, pix_even_o, array_end_o, done_o, read_idx_o,
                     ph, st, row, exp_rt[1:0], col, odd, even, aend, dn, rd);
        end
        checks++;
        if ($countones(phase_o) > 1) begin
            fails++;
            $display("FAIL R12: phase=%b expected at most one bit set", phase_o);
        end
    endtask

    task automatic scan(int rd, bit final_rd);
        for (int r = 0; r < ROWS; r++) begin
            chk_cyc("R4", 4'b0010, 2'b00, r, 0, 0, 0, 0, 0, rd);
            for (int c = 0; c < COLS; c++) begin
                chk_cyc("R5", 4'b0100, 2'b00, r, c, 1, 0, 0, 0, rd);
                chk_cyc("R5", 4'b0100, 2'b00, r, c, 0, 1, 0, 0, rd);
            end
            chk_cyc("R5", 4'b0010, 2'b00, r, COLS, 0, 0, 0, 0, rd);
        end
        chk_cyc(final_rd ? (rd == 2 ? "R7" : "R6") : "R3",
                4'b0010, 2'b00, ROWS - 1, 0, 0, 0, 1, final_rd, rd);
    endtask

    // Full-frame trace; poke raises a second start mid-frame with other settings
    task automatic run_trace(bit dbl, int len, bit poke);
        read_flag_i  = dbl;
        int_cycles_i = INT_W'(len);
        start_i      = 1'b1;
        @(posedge clk);
        #1 start_i = 1'b0;
        for (int k = 0; k < CL; k++) begin
            chk_cyc(poke ? "R9" : "R2", 4'b0001, 2'b01, 0, 0, 0, 0, 0, 0, 1);
            if (poke && k == 0) begin
                start_i      = 1'b1;
                read_flag_i  = ~dbl;
                int_cycles_i = INT_W'(7);
            end else begin
                start_i = 1'b0;
            end
        end
        start_i = 1'b0;
        for (int k = 0; k < RR; k++) chk_cyc("R2", 4'b0001, 2'b10, 0, 0, 0, 0, 0, 0, 1);
        for (int k = 0; k < GR; k++) chk_cyc("R2", 4'b0001, 2'b11, 0, 0, 0, 0, 0, 0, 1);
        scan(1, !dbl);
        if (dbl) begin
            for (int k = 0; k < ((len == 0) ? 1 : len); k++)
                chk_cyc((len == 0) ? "R8" : "R7", 4'b1000, 2'b00, 0, 0, 0, 0, 0, 0, 1);
            for (int k = 0; k < CL; k++) chk_cyc("R7", 4'b0001, 2'b01, 0, 0, 0, 0, 0, 0, 2);
            scan(2, 1'b1);
        end
        chk_cyc("R10", 4'b0000, 2'b00, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic t_reset_state();
        chk_cyc("R1", 4'b0000, 2'b00, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic t_single_read();
        run_trace(1'b0, 3, 1'b0);
    endtask

    task automatic t_double_read();
        run_trace(1'b1, 4, 1'b0);
    endtask

    task automatic t_zero_integration();
        run_trace(1'b1, 0, 1'b0);
    endtask

    task automatic t_busy_start_ignored();
        run_trace(1'b0, 2, 1'b1);
    endtask

    task automatic t_midframe_reset();
        read_flag_i  = 1'b1;
        int_cycles_i = INT_W'(5);
        start_i      = 1'b1;
        @(posedge clk);
        #1 start_i = 1'b0;
        repeat (CL + RR + GR + 12) @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1 rst = 1'b0;
        chk_cyc("R11", 4'b0000, 2'b00, 0, 0, 0, 0, 0, 0, 0);
        chk_cyc("R11", 4'b0000, 2'b00, 0, 0, 0, 0, 0, 0, 0);
        run_trace(1'b0, 0, 1'b0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        t_reset_state();
        t_single_read();
        t_double_read();
        t_zero_integration();
        t_busy_start_ignored();
        t_midframe_reset();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL R10 watchdog: got no completion, expected all frames done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule